// File: doc/BRIEF.md
# Programmable Down Counter with Terminal Count

This block is a binary down counter, 8 bits wide by default, for building divide-by-n stages and programmable timers. On every rising clock edge with no control active, the count drops by one. After zero, the next edge wraps the count to the all-ones value, so a free-running counter repeats every 2^WIDTH clocks.

The count can be set in four ways. An asynchronous clear forces it to all-ones. An asynchronous load copies the preset word into the counter at once. A synchronous load copies the preset word on the next edge. A count-inhibit input freezes it.

An active-low terminal-count output marks the cycle in which the count is zero, but only while counting is allowed. Feeding one stage's terminal-count output into the next stage's inhibit input chains stages into a longer counter.

Top module: `prog_down_counter`

## Requirements
- R1: Driving `mr_n` low forces the count to all-ones (255 at WIDTH=8) at once, without a clock edge. After `mr_n` returns high with nothing else active, `tc_n` goes low after exactly 255 rising edges.
- R2: With `mr_n`, `aload_n` and `sload_n` high and `inhibit` low, each rising edge lowers the count by one. After a synchronous load of n, `tc_n` goes low exactly n edges later.
- R3: While `inhibit` is high and no load or clear is active, the count keeps its value across clock edges.
- R4: `tc_n` is low exactly when the count is zero and `inhibit` is low. It responds to `inhibit` with no clock edge, and in free counting it stays low for one clock period.
- R5: With `sload_n` low, the rising edge loads `preset` whatever the value of `inhibit`. Before that edge the count is unchanged.
- R6: Driving `aload_n` low copies `preset` into the counter at once. It takes precedence over `sload_n`, `inhibit` and the clock for as long as it stays low.
- R7: `mr_n` takes precedence over `aload_n` and `sload_n`. With a load active as well, the count still becomes all-ones.
- R8: From a count of zero with every control inactive, the next edge gives all-ones. Successive `tc_n` pulses in free counting are 256 edges apart.
- R9: Two stages chained synchronously give a combined count. The upper stage's inhibit is driven by the lower stage's `tc_n`, and the two share the clock and load controls. Loading lower=a and upper=b makes the upper `tc_n` go low exactly b*256+a edges after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mr_n | input | 1 | Asynchronous clear to all-ones, active low, highest priority |
| aload_n | input | 1 | Asynchronous load of `preset`, active low |
| sload_n | input | 1 | Synchronous load of `preset`, active low |
| inhibit | input | 1 | Count inhibit, active high; also gates `tc_n` |
| preset | input | WIDTH | Word to load |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The count is not brought out, so the only thing visible at the ports is the timing of `tc_n`. A wrong count appears as a terminal-count pulse at the wrong edge, and the error shows within one full count cycle (at most 256 edges). A wrong priority or a lost async action appears at once as the wrong `tc_n` level. A wrong wrap value shows up as a changed spacing between successive pulses, and a chained stage amplifies any error in the lower stage by a factor of 256.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    PDC_HOLD = 2'd0,
    PDC_LOAD = 2'd1,
    PDC_DEC  = 2'd2
  } pdc_act_e;
endpackage

// File: rtl/pdc_act_decode.sv
module pdc_act_decode
  import pdc_pkg::*;
(
  input  logic     sload_n,
  input  logic     inhibit,
  output pdc_act_e act
);
  // Synchronous priority: load beats inhibit, inhibit beats decrement.
  always_comb begin
    if (!sload_n)     act = PDC_LOAD;
    else if (inhibit) act = PDC_HOLD;
    else              act = PDC_DEC;
  end
endmodule

// File: rtl/pdc_next.sv
module pdc_next
  import pdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  pdc_act_e           act,
  input  logic [WIDTH-1:0]   cnt,
  input  logic [WIDTH-1:0]   preset,
  output logic [WIDTH-1:0]   nxt
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modulo subtraction gives the zero-to-all-ones wrap without a special case.
  always_comb begin
    unique case (act)
      PDC_LOAD: nxt = preset;
      PDC_DEC:  nxt = cnt - ONE;
      default:  nxt = cnt;
    endcase
  end
endmodule

// File: rtl/pdc_state.sv
module pdc_state #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             aload_n,
  input  logic [WIDTH-1:0] preset,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Clear outranks the asynchronous load; both outrank the clock.
  always_ff @(posedge clk or negedge mr_n or negedge aload_n) begin
    if (!mr_n)         q <= ALL_ONES;
    else if (!aload_n) q <= preset;
    else               q <= nxt;
  end
endmodule

// File: rtl/pdc_tc.sv
module pdc_tc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             inhibit,
  output logic             tc_n
);
  logic [WIDTH:0] nz_chain;

  // Ripple OR of the count bits: nz_chain[WIDTH] is high for any non-zero count.
  assign nz_chain[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_zdet
    assign nz_chain[i+1] = nz_chain[i] | cnt[i];
  end

  assign tc_n = nz_chain[WIDTH] | inhibit;
endmodule

// File: rtl/prog_down_counter.sv
module prog_down_counter
  import pdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             inhibit,
  input  logic [WIDTH-1:0] preset,
  output logic             tc_n
);
  pdc_act_e         act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  pdc_act_decode u_dec (
    .sload_n (sload_n),
    .inhibit (inhibit),
    .act     (act)
  );

  pdc_next #(.WIDTH(WIDTH)) u_next (
    .act    (act),
    .cnt    (cnt_q),
    .preset (preset),
    .nxt    (cnt_d)
  );

  pdc_state #(.WIDTH(WIDTH)) u_state (
    .clk     (clk),
    .mr_n    (mr_n),
    .aload_n (aload_n),
    .preset  (preset),
    .nxt     (cnt_d),
    .q       (cnt_q)
  );

  pdc_tc #(.WIDTH(WIDTH)) u_tc (
    .cnt     (cnt_q),
    .inhibit (inhibit),
    .tc_n    (tc_n)
  );
endmodule

// File: rtl/prog_down_counter_chk.sv
module prog_down_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             mr_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             inhibit,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] cnt,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  // R1 / R7: a held clear leaves all-ones in place, whatever load is active
  a_r7_clear_wins: assert property (@(posedge clk)
    !mr_n |-> cnt == ALL_ONES);

  // R6: a held asynchronous load keeps the preset word in the counter
  a_r6_async_load: assert property (@(posedge clk) disable iff (!mr_n)
    !aload_n |-> cnt == preset);

  // R2: a plain edge from a non-zero count lowers it by one
  a_r2_decrement: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    ($past(mr_n && aload_n && sload_n && !inhibit) && $past(cnt) != '0)
      |-> cnt == $past(cnt) - ONE);

  // R3: inhibit with no load holds the count
  a_r3_hold: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    $past(mr_n && aload_n && sload_n && inhibit) |-> $stable(cnt));

  // R5: synchronous load takes the preset sampled at the edge
  a_r5_sync_load: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    $past(mr_n && aload_n && !sload_n) |-> cnt == $past(preset));

  // R4: terminal count never shows while inhibited
  a_r4_tc_gated: assert property (@(posedge clk) disable iff (!mr_n)
    inhibit |-> tc_n);

  // R8: a terminal-count cycle in free counting is followed by all-ones
  a_r8_wrap: assert property (@(posedge clk) disable iff (!mr_n || !aload_n)
    (!tc_n && sload_n) |=> cnt == ALL_ONES);
endmodule

bind prog_down_counter prog_down_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .mr_n    (mr_n),
  .aload_n (aload_n),
  .sload_n (sload_n),
  .inhibit (inhibit),
  .preset  (preset),
  .cnt     (cnt_q),
  .tc_n    (tc_n)
);

// File: tb/prog_down_counter_tb.sv
module prog_down_counter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         mr_n = 1'b1;
  logic         aload_n = 1'b1;
  logic         sload_n = 1'b1;
  logic         inhibit = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] preset_hi = '0;
  logic         tc_n;
  logic         tc_hi_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  prog_down_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .mr_n(mr_n), .aload_n(aload_n), .sload_n(sload_n),
    .inhibit(inhibit), .preset(preset), .tc_n(tc_n)
  );

  // Upper stage for the chaining test (R9), enabled by the lower stage
  prog_down_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .mr_n(mr_n), .aload_n(aload_n), .sload_n(sload_n),
    .inhibit(tc_n), .preset(preset_hi), .tc_n(tc_hi_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_to_tc(output int n, input int limit);
    n = 0;
    while (tc_n && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic sync_load(input logic [W-1:0] v);
    preset  = v;
    sload_n = 1'b0;
    step();
    sload_n = 1'b1;
  endtask

  task automatic t_reset();
    int n;
    #1 mr_n = 1'b0;
    step(); step();
    check(tc_n == 1'b1, "R1 reset state tc_n", tc_n, 1);
    mr_n = 1'b0;
    step();
    mr_n = 1'b1;
    run_to_tc(n, 300);
    check(n == 255, "R1 edges from clear to zero", n, 255);
  endtask

  task automatic t_count(input int v);
    int n;
    sync_load(v[W-1:0]);
    run_to_tc(n, 300);
    check(n == v, "R2 edges from load to terminal count", n, v);
  endtask

  task automatic t_inhibit();
    int n;
    sync_load(8'd5);
    step(); step();
    inhibit = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      check(tc_n == 1'b1, "R3 tc_n while inhibited", tc_n, 1);
    end
    inhibit = 1'b0;
    run_to_tc(n, 300);
    check(n == 3, "R3 count held during inhibit", n, 3);
    // at zero: inhibit masks tc_n without a clock edge
    inhibit = 1'b1;
    #1;
    check(tc_n == 1'b1, "R4 inhibit masks tc_n at once", tc_n, 1);
    step();
    inhibit = 1'b0;
    #1;
    check(tc_n == 1'b0, "R4 tc_n back low, zero held", tc_n, 0);
    step();
    check(tc_n == 1'b1, "R4 tc_n low for one period", tc_n, 1);
  endtask

  task automatic t_wrap();
    int n;
    sync_load(8'd2);
    run_to_tc(n, 300);
    step();
    check(tc_n == 1'b1, "R8 leaves zero after one edge", tc_n, 1);
    run_to_tc(n, 300);
    check(n + 1 == 256, "R8 spacing of tc pulses", n + 1, 256);
  endtask

  task automatic t_sload();
    int n;
    inhibit = 1'b1;
    sync_load(8'd4);
    step(); step();
    inhibit = 1'b0;
    run_to_tc(n, 300);
    check(n == 4, "R5 load despite inhibit", n, 4);
    sync_load(8'd9);
    preset  = 8'd0;
    sload_n = 1'b0;
    #1;
    check(tc_n == 1'b1, "R5 no change before edge", tc_n, 1);
    step();
    sload_n = 1'b1;
    check(tc_n == 1'b0, "R5 loaded at edge", tc_n, 0);
  endtask

  task automatic t_aload();
    sync_load(8'd9);
    #1;
    preset  = 8'd0;
    sload_n = 1'b0;
    aload_n = 1'b0;
    #1;
    check(tc_n == 1'b0, "R6 async load without edge", tc_n, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      check(tc_n == 1'b0, "R6 async load holds over clock", tc_n, 0);
    end
    sload_n = 1'b1;
    aload_n = 1'b1;
    step();
    check(tc_n == 1'b1, "R6 counting resumes after release", tc_n, 1);
  endtask

  task automatic t_clear_priority();
    int n;
    preset  = 8'd0;
    aload_n = 1'b0;
    #1;
    check(tc_n == 1'b0, "R6 async load of zero", tc_n, 0);
    mr_n = 1'b0;
    #1;
    check(tc_n == 1'b1, "R1 clear acts without edge", tc_n, 1);
    step();
    check(tc_n == 1'b1, "R7 clear beats async load", tc_n, 1);
    mr_n = 1'b1;
    aload_n = 1'b1;
    run_to_tc(n, 300);
    check(n == 255, "R7 count was all-ones", n, 255);
    mr_n = 1'b0;
    sload_n = 1'b0;
    preset = 8'd0;
    step();
    check(tc_n == 1'b1, "R7 clear beats sync load", tc_n, 1);
    mr_n = 1'b1;
    sload_n = 1'b1;
    run_to_tc(n, 300);
    check(n == 255, "R7 count was all-ones after sync load", n, 255);
  endtask

  task automatic t_chain();
    int n;
    preset_hi = 8'd2;
    sync_load(8'd3);
    n = 0;
    while (tc_hi_n && n < 700) begin
      step();
      n++;
    end
    check(n == 515, "R9 chained edges to combined zero", n, 515);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count(1);
    t_count(7);
    t_count(100);
    t_count(0);
    t_inhibit();
    t_wrap();
    t_sload();
    t_aload();
    t_clear_priority();
    t_chain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule